// File: doc/BRIEF.md
# Endpoint Buffer Data Port Controller

This block gives a microcontroller word-wide access to per-endpoint packet buffers through a single 16-bit data port. An index register picks the endpoint number and the direction, or the dedicated SETUP buffer of endpoint 0. Every data-port access moves a byte pointer on by two. For a transmit (IN) endpoint, the microcontroller writes words into the buffer. The buffer is handed to the packet engine automatically when the byte count reaches the endpoint's max packet size. For a shorter packet, the microcontroller sets a buffer length and issues a validate command. For a receive (OUT) endpoint, the microcontroller reads words back in order, and the buffer is released when the last received byte has been read.

A control register carries one-shot commands: clear buffer, validate, stall set and clear, data-stage enable, and status handshake. A per-endpoint configuration register holds the max packet size, the enable bit, the double-buffer bit, a 2-bit type field and a bit that suppresses empty packets. The packet engine sits outside this block. It fills OUT buffers and commits their length through a simple side port. It reads validated IN buffers and acknowledges them through the same side port.

Top module: `epdp_top`

## Requirements
- R1: The index register (address 0) holds the endpoint number in bits [3:0], the direction in bit 4 (1 = IN) and the SETUP select in bit 5. It reads back at address 0, and after reset it and all full and stall flags are 0.
- R2: A data-port write (address 2) to an enabled IN endpoint whose buffer is not full stores the word at the current byte count and raises the count by 2. The count reads back at address 3.
- R3: When a data-port write brings the IN count to the max packet size, the buffer becomes full with packet length equal to the max packet size, and the count returns to 0.
- R4: Data-port writes to a full IN buffer, or to an endpoint whose enable bit is 0, change neither the count nor the full flag.
- R5: A validate command (control register, address 1, bit 3) on a non-full IN buffer marks it full with packet length equal to the buffer length register (address 5), and resets the count to 0.
- R6: A validate with buffer length 0 produces a zero-length packet, unless the no-empty bit (configuration bit 15) is set, in which case the command is ignored.
- R7: Each data-port read of a full OUT buffer returns the next received word in order and lowers the remaining count by 2. The read that consumes the last byte releases the buffer.
- R8: A data-port read of an OUT buffer that is not full returns 0 and changes nothing.
- R9: A clear command (control bit 4) empties the selected buffer. For IN this means count 0 and not full; for OUT it means not full.
- R10: Control bit 0 sets and control bit 5 clears the stall flag of the indexed endpoint. The flag is driven on `stall` and reads at address 1 bit 0.
- R11: Control bit 1 (status handshake) and bit 2 (data-stage enable) each give a one-cycle pulse in the cycle after the write, with the endpoint number on `pulse_ep`.
- R12: With the SETUP select set, data-port reads come from the SETUP buffer, which is engine slot NUM_EP. This works whatever the endpoint-0 enable bit is.
- R13: An engine acknowledge on a full IN slot clears its full flag.
- R14: The configuration register (address 4) holds the max packet size in [10:0], the type in [12:11], double-buffer in 13, enable in 14 and no-empty in 15. After reset the max packet size equals the buffer size in bytes and the other fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data port) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| eng_out_we | input | 1 | Engine write into an OUT buffer |
| eng_out_slot | input | SLOTW | OUT slot; NUM_EP selects the SETUP buffer |
| eng_out_addr | input | AW | OUT buffer word address |
| eng_out_wdata | input | 16 | OUT buffer write word |
| eng_out_commit | input | 1 | Marks the OUT slot full with eng_out_len bytes |
| eng_out_len | input | BW | Received byte count |
| eng_in_slot | input | EPW | IN slot read by the engine |
| eng_in_addr | input | AW | IN buffer word address |
| eng_in_rdata | output | 16 | IN buffer word |
| eng_in_len | output | BW | Packet length of the selected IN slot |
| eng_in_ack | input | 1 | Engine has sent the selected IN slot |
| in_full | output | NUM_EP | IN buffer full flags |
| out_full | output | NUM_EP+1 | OUT buffer full flags (top bit: SETUP) |
| stall | output | NUM_EP | Stall flags |
| status_pulse | output | 1 | Status-stage handshake pulse |
| dstage_pulse | output | 1 | Data-stage enable pulse |
| pulse_ep | output | 4 | Endpoint of the pulse |

## Verification
A wrong byte count shows up at once in the count register. It also moves the moment an IN buffer turns full by a whole word, so `in_full` rises one write early or late. A wrong read pointer returns words out of order on the very next data-port pop. A wrong remaining count moves the release of `out_full` to a different pop. Mis-decoded control bits appear on `stall` or the pulse outputs on the cycle after the write.

// File: rtl/epdp_pkg.sv
package epdp_pkg;

    typedef enum logic [2:0] {
        RA_INDEX = 3'd0,
        RA_CTRL  = 3'd1,
        RA_DATA  = 3'd2,
        RA_COUNT = 3'd3,
        RA_CFG   = 3'd4,
        RA_BLEN  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       setup;
        logic       dir_in;
        logic [3:0] ep;
    } index_t;

    typedef struct packed {
        logic ep_ok;
        logic in_sel;
        logic out_sel;
        logic wr_index;
        logic wr_cfg;
        logic wr_blen;
        logic data_wr;
        logic data_rd;
        logic validate;
        logic clear;
        logic stall_set;
        logic stall_clr;
        logic status;
        logic dstage;
    } cmd_t;

    localparam int CB_STALL   = 0;
    localparam int CB_STATUS  = 1;
    localparam int CB_DSTAGE  = 2;
    localparam int CB_VALID   = 3;
    localparam int CB_CLEAR   = 4;
    localparam int CB_UNSTALL = 5;

endpackage

// File: rtl/epdp_ram.sv
module epdp_ram #(
    parameter int WORDS = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/epdp_decode.sv
module epdp_decode
    import epdp_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [5:0]        ctrl_bits,
    input  index_t            idx,
    input  logic [NUM_EP-1:0] ep_en,
    output cmd_t              cmd
);
    logic ep_ok, en, ctrl_wr;

    always_comb begin
        ep_ok   = int'(idx.ep) < NUM_EP;
        en      = ep_ok && ep_en[idx.ep[EPW-1:0]];
        ctrl_wr = reg_wr && (reg_addr == RA_CTRL);

        cmd           = '0;
        cmd.ep_ok     = ep_ok;
        cmd.in_sel    = !idx.setup && idx.dir_in && en;
        cmd.out_sel   = idx.setup || (!idx.dir_in && en);
        cmd.wr_index  = reg_wr && (reg_addr == RA_INDEX);
        cmd.wr_cfg    = reg_wr && (reg_addr == RA_CFG) && ep_ok;
        cmd.wr_blen   = reg_wr && (reg_addr == RA_BLEN) && ep_ok;
        cmd.data_wr   = reg_wr && (reg_addr == RA_DATA);
        cmd.data_rd   = reg_rd && (reg_addr == RA_DATA);
        cmd.validate  = ctrl_wr && ctrl_bits[CB_VALID];
        cmd.clear     = ctrl_wr && ctrl_bits[CB_CLEAR];
        cmd.stall_set = ctrl_wr && ctrl_bits[CB_STALL] && ep_ok;
        cmd.stall_clr = ctrl_wr && ctrl_bits[CB_UNSTALL] && ep_ok;
        cmd.status    = ctrl_wr && ctrl_bits[CB_STATUS] && ep_ok;
        cmd.dstage    = ctrl_wr && ctrl_bits[CB_DSTAGE] && ep_ok;
    end
endmodule

// File: rtl/epdp_top.sv
module epdp_top
    import epdp_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int BUF_BYTES = 64,
    localparam int WORDS = BUF_BYTES / 2,
    localparam int AW    = $clog2(WORDS),
    localparam int BW    = $clog2(BUF_BYTES + 1),
    localparam int NOUT  = NUM_EP + 1,
    localparam int SLOTW = $clog2(NOUT),
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             eng_out_we,
    input  logic [SLOTW-1:0] eng_out_slot,
    input  logic [AW-1:0]    eng_out_addr,
    input  logic [15:0]      eng_out_wdata,
    input  logic             eng_out_commit,
    input  logic [BW-1:0]    eng_out_len,
    input  logic [EPW-1:0]   eng_in_slot,
    input  logic [AW-1:0]    eng_in_addr,
    output logic [15:0]      eng_in_rdata,
    output logic [BW-1:0]    eng_in_len,
    input  logic             eng_in_ack,
    output logic [NUM_EP-1:0] in_full,
    output logic [NOUT-1:0]  out_full,
    output logic [NUM_EP-1:0] stall,
    output logic             status_pulse,
    output logic             dstage_pulse,
    output logic [3:0]       pulse_ep
);
    typedef struct packed {
        index_t                        idx;
        logic [NUM_EP-1:0][BW-1:0]     mps;
        logic [NUM_EP-1:0][1:0]        typ;
        logic [NUM_EP-1:0]             dbl;
        logic [NUM_EP-1:0]             en;
        logic [NUM_EP-1:0]             noempty;
        logic [NUM_EP-1:0][BW-1:0]     blen;
        logic [NUM_EP-1:0][BW-1:0]     in_cnt;
        logic [NUM_EP-1:0][BW-1:0]     in_len;
        logic [NUM_EP-1:0]             in_full;
        logic [NOUT-1:0][BW-1:0]       out_rptr;
        logic [NOUT-1:0][BW-1:0]       out_rem;
        logic [NOUT-1:0]               out_full;
        logic [NUM_EP-1:0]             stall;
        logic                          st_p;
        logic                          ds_p;
        logic [3:0]                    p_ep;
    } state_t;

    state_t s_q, s_d;
    cmd_t   cmd;

    logic [EPW-1:0]          e;
    logic [SLOTW-1:0]        oslot;
    logic                    in_we;
    logic [BW-1:0]           nxt_cnt;
    logic [NUM_EP-1:0][15:0] in_rd;
    logic [NOUT-1:0][15:0]   out_rd;

    epdp_decode #(.NUM_EP(NUM_EP)) u_decode (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .ctrl_bits (reg_wdata[5:0]),
        .idx       (s_q.idx),
        .ep_en     (s_q.en),
        .cmd       (cmd)
    );

    assign e     = s_q.idx.ep[EPW-1:0];
    assign oslot = s_q.idx.setup ? SLOTW'(NUM_EP) : SLOTW'(s_q.idx.ep[EPW-1:0]);
    assign in_we = cmd.data_wr && cmd.in_sel && !s_q.in_full[e];

    genvar g;
    generate
        for (g = 0; g < NUM_EP; g++) begin : g_in
            epdp_ram #(.WORDS(WORDS)) u_in_ram (
                .clk   (clk),
                .we    (in_we && (e == EPW'(g))),
                .waddr (s_q.in_cnt[g][AW:1]),
                .wdata (reg_wdata),
                .raddr (eng_in_addr),
                .rdata (in_rd[g])
            );
        end
        for (g = 0; g < NOUT; g++) begin : g_out
            epdp_ram #(.WORDS(WORDS)) u_out_ram (
                .clk   (clk),
                .we    (eng_out_we && (eng_out_slot == SLOTW'(g))),
                .waddr (eng_out_addr),
                .wdata (eng_out_wdata),
                .raddr (s_q.out_rptr[g][AW:1]),
                .rdata (out_rd[g])
            );
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.st_p = cmd.status;
        s_d.ds_p = cmd.dstage;
        s_d.p_ep = (cmd.status || cmd.dstage) ? s_q.idx.ep : 4'd0;
        nxt_cnt  = s_q.in_cnt[e] + BW'(2);

        if (eng_in_ack) s_d.in_full[eng_in_slot] = 1'b0;

        if (cmd.wr_index) s_d.idx = index_t'(reg_wdata[5:0]);
        if (cmd.wr_cfg) begin
            s_d.mps[e]     = reg_wdata[BW-1:0];
            s_d.typ[e]     = reg_wdata[12:11];
            s_d.dbl[e]     = reg_wdata[13];
            s_d.en[e]      = reg_wdata[14];
            s_d.noempty[e] = reg_wdata[15];
        end
        if (cmd.wr_blen) s_d.blen[e] = reg_wdata[BW-1:0];

        if (in_we) begin
            if (nxt_cnt >= s_q.mps[e]) begin
                s_d.in_full[e] = 1'b1;
                s_d.in_len[e]  = s_q.mps[e];
                s_d.in_cnt[e]  = '0;
            end else begin
                s_d.in_cnt[e]  = nxt_cnt;
            end
        end

        if (cmd.validate && cmd.in_sel && !s_q.in_full[e]
            && !(s_q.blen[e] == '0 && s_q.noempty[e])) begin
            s_d.in_full[e] = 1'b1;
            s_d.in_len[e]  = s_q.blen[e];
            s_d.in_cnt[e]  = '0;
        end

        if (cmd.data_rd && cmd.out_sel && s_q.out_full[oslot]) begin
            if (s_q.out_rem[oslot] <= BW'(2)) begin
                s_d.out_full[oslot] = 1'b0;
                s_d.out_rptr[oslot] = '0;
                s_d.out_rem[oslot]  = '0;
            end else begin
                s_d.out_rptr[oslot] = s_q.out_rptr[oslot] + BW'(2);
                s_d.out_rem[oslot]  = s_q.out_rem[oslot] - BW'(2);
            end
        end

        if (cmd.clear && cmd.in_sel) begin
            s_d.in_full[e] = 1'b0;
            s_d.in_cnt[e]  = '0;
        end
        if (cmd.clear && cmd.out_sel) begin
            s_d.out_full[oslot] = 1'b0;
            s_d.out_rptr[oslot] = '0;
            s_d.out_rem[oslot]  = '0;
        end

        if (cmd.stall_set) s_d.stall[e] = 1'b1;
        if (cmd.stall_clr) s_d.stall[e] = 1'b0;

        if (eng_out_commit) begin
            s_d.out_full[eng_out_slot] = 1'b1;
            s_d.out_rem[eng_out_slot]  = eng_out_len;
            s_d.out_rptr[eng_out_slot] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < NUM_EP; i++) s_q.mps[i] <= BW'(BUF_BYTES);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_INDEX: reg_rdata = {10'd0, s_q.idx};
            RA_CTRL:  reg_rdata = {15'd0, cmd.ep_ok && s_q.stall[e]};
            RA_DATA:  reg_rdata = (cmd.out_sel && s_q.out_full[oslot]) ? out_rd[oslot] : 16'd0;
            RA_COUNT: reg_rdata = cmd.in_sel  ? 16'(s_q.in_cnt[e]) :
                                  cmd.out_sel ? 16'(s_q.out_rem[oslot]) : 16'd0;
            RA_CFG:   reg_rdata = cmd.ep_ok ? {s_q.noempty[e], s_q.en[e], s_q.dbl[e],
                                               s_q.typ[e], 11'(s_q.mps[e])} : 16'd0;
            RA_BLEN:  reg_rdata = cmd.ep_ok ? 16'(s_q.blen[e]) : 16'd0;
            default:  reg_rdata = '0;
        endcase
    end

    assign eng_in_rdata = in_rd[eng_in_slot];
    assign eng_in_len   = s_q.in_len[eng_in_slot];
    assign in_full      = s_q.in_full;
    assign out_full     = s_q.out_full;
    assign stall        = s_q.stall;
    assign status_pulse = s_q.st_p;
    assign dstage_pulse = s_q.ds_p;
    assign pulse_ep     = s_q.p_ep;
endmodule

// File: rtl/epdp_checker.sv
module epdp_checker #(
    parameter int NUM_EP    = 4,
    localparam int NOUT = NUM_EP + 1,
    localparam int EPW  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_addr,
    input logic              eng_in_ack,
    input logic [EPW-1:0]    eng_in_slot,
    input logic [NUM_EP-1:0] in_full,
    input logic [NOUT-1:0]   out_full,
    input logic              status_pulse,
    input logic              dstage_pulse
);
    // R3 and R5: an IN buffer only turns full after a microcontroller write
    assert_in_fill_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_full & ~$past(in_full)) != '0) |-> $past(reg_wr));

    assert_ack_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_in_ack && in_full[eng_in_slot]) |=> !in_full[$past(eng_in_slot)]);

    // R7 and R9: an OUT buffer is only released by a read or a clear command
    assert_release_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~out_full & $past(out_full)) != '0) |-> $past(reg_rd || reg_wr));

    assert_pulse_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_pulse || dstage_pulse) |-> $past(reg_wr && reg_addr == 3'd1));
endmodule

bind epdp_top epdp_checker #(.NUM_EP(NUM_EP)) u_epdp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .eng_in_ack   (eng_in_ack),
    .eng_in_slot  (eng_in_slot),
    .in_full      (in_full),
    .out_full     (out_full),
    .status_pulse (status_pulse),
    .dstage_pulse (dstage_pulse)
);

// File: tb/epdp_top_bench.sv
module epdp_top_bench;
    localparam int NUM_EP = 4;
    localparam int BUF_BYTES = 64;
    localparam int AW = 5, BW = 7, SLOTW = 3, EPW = 2;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic eng_out_we = 0, eng_out_commit = 0, eng_in_ack = 0;
    logic [SLOTW-1:0] eng_out_slot = 0;
    logic [AW-1:0] eng_out_addr = 0, eng_in_addr = 0;
    logic [15:0] eng_out_wdata = 0, eng_in_rdata;
    logic [BW-1:0] eng_out_len = 0, eng_in_len;
    logic [EPW-1:0] eng_in_slot = 0;
    logic [NUM_EP-1:0] in_full, stall;
    logic [NUM_EP:0] out_full;
    logic status_pulse, dstage_pulse;
    logic [3:0] pulse_ep;

    int checks = 0, fails = 0;
    int exp_q[$];
    string tag_q[$];
    logic [15:0] v;

    always #10 clk = ~clk;

    epdp_top #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES)) u_epdp_top (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic reg_peek(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #2; d = reg_rdata;
    endtask

    // driver: pushes the expected word, then pops the data port
    task automatic port_pop(input string tag, input int exp);
        @(negedge clk); exp_q.push_back(exp); tag_q.push_back(tag);
        reg_rd = 1; reg_addr = 3'd2;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic eng_write(input int slot, input int a, input logic [15:0] d);
        @(negedge clk); eng_out_we = 1; eng_out_slot = SLOTW'(slot);
        eng_out_addr = AW'(a); eng_out_wdata = d;
        @(negedge clk); eng_out_we = 0;
    endtask

    task automatic eng_commit(input int slot, input int len);
        @(negedge clk); eng_out_commit = 1; eng_out_slot = SLOTW'(slot); eng_out_len = BW'(len);
        @(negedge clk); eng_out_commit = 0;
    endtask

    task automatic eng_ack(input int slot);
        @(negedge clk); eng_in_ack = 1; eng_in_slot = EPW'(slot);
        @(negedge clk); eng_in_ack = 0;
    endtask

    task automatic eng_peek(input int slot, input int a, output logic [15:0] d);
        @(negedge clk); eng_in_slot = EPW'(slot); eng_in_addr = AW'(a); #2; d = eng_in_rdata;
    endtask

    // monitor: compares every data-port pop against the scoreboard
    initial forever begin
        @(negedge clk); #5;
        if (reg_rd && reg_addr == 3'd2) begin
            if (exp_q.size() == 0) check("R7 unexpected pop", 1, 0);
            else check(tag_q.pop_front(), int'(reg_rdata), exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R14 reset state
        reg_peek(3'd0, v); check("R1 index reset", v, 0);
        check("R1 flags reset", {in_full, out_full, stall}, 0);
        reg_peek(3'd4, v); check("R14 cfg reset", v, 16'h0040);

        // R4 disabled endpoint ignores writes
        reg_write(3'd0, 16'h0012);
        reg_write(3'd2, 16'h9999);
        reg_write(3'd4, 16'h4040);
        reg_peek(3'd3, v); check("R4 disabled count", v, 0);

        // R1 / R14 configure ep1 IN, mps 8
        reg_write(3'd0, 16'h0011);
        reg_peek(3'd0, v); check("R1 index readback", v, 16'h0011);
        reg_write(3'd4, 16'h6808);
        reg_peek(3'd4, v); check("R14 cfg readback", v, 16'h6808);
        reg_write(3'd4, 16'h4008);

        // R2 / R3 fill and auto-validate
        reg_write(3'd2, 16'h1111);
        reg_write(3'd2, 16'h2222);
        reg_write(3'd2, 16'h3333);
        reg_peek(3'd3, v); check("R2 count", v, 6);
        check("R3 not yet full", in_full[1], 0);
        reg_write(3'd2, 16'h4444);
        check("R3 auto full", in_full[1], 1);
        eng_peek(1, 0, v); check("R3 length", eng_in_len, 8);
        check("R2 word0", v, 16'h1111);
        eng_peek(1, 3, v); check("R2 word3", v, 16'h4444);
        reg_peek(3'd3, v); check("R3 count reset", v, 0);
        reg_write(3'd2, 16'h5555);
        reg_peek(3'd3, v); check("R4 full ignores write", v, 0);
        eng_peek(1, 0, v); check("R4 data kept", v, 16'h1111);

        // R13 acknowledge
        eng_ack(1);
        check("R13 ack clears", in_full[1], 0);

        // R5 manual validate of short packet
        reg_write(3'd2, 16'hAAAA);
        reg_write(3'd2, 16'hBBBB);
        reg_write(3'd5, 16'd3);
        reg_write(3'd1, 16'h0008);
        check("R5 validate full", in_full[1], 1);
        eng_peek(1, 1, v); check("R5 length", eng_in_len, 3);
        reg_peek(3'd3, v); check("R5 count reset", v, 0);
        eng_ack(1);

        // R6 empty packet suppression
        reg_write(3'd4, 16'hC008);
        reg_write(3'd5, 16'd0);
        reg_write(3'd1, 16'h0008);
        check("R6 suppressed", in_full[1], 0);
        reg_write(3'd4, 16'h4008);
        reg_write(3'd1, 16'h0008);
        check("R6 zero packet", in_full[1], 1);
        eng_peek(1, 0, v); check("R6 zero length", eng_in_len, 0);
        eng_ack(1);

        // R9 clear IN
        reg_write(3'd2, 16'h7777);
        reg_write(3'd1, 16'h0010);
        reg_peek(3'd3, v); check("R9 in count cleared", v, 0);

        // R7 / R8 OUT on ep2
        reg_write(3'd0, 16'h0002);
        eng_write(2, 0, 16'h0102);
        eng_write(2, 1, 16'h0304);
        eng_write(2, 2, 16'h0506);
        eng_commit(2, 5);
        check("R7 out full", out_full[2], 1);
        reg_peek(3'd3, v); check("R7 remaining", v, 5);
        port_pop("R7 word0", 16'h0102);
        reg_peek(3'd3, v); check("R7 remaining after pop", v, 3);
        port_pop("R7 word1", 16'h0304);
        check("R7 not released early", out_full[2], 1);
        port_pop("R7 word2", 16'h0506);
        check("R7 released", out_full[2], 0);
        port_pop("R8 empty read", 0);
        reg_peek(3'd3, v); check("R8 no effect", v, 0);

        // R9 clear OUT
        eng_commit(2, 4);
        reg_write(3'd1, 16'h0010);
        check("R9 out cleared", out_full[2], 0);

        // R12 SETUP buffer with ep0 disabled
        eng_write(4, 0, 16'hCAFE);
        eng_commit(4, 2);
        reg_write(3'd0, 16'h0020);
        port_pop("R12 setup word", 16'hCAFE);
        check("R12 setup released", out_full[4], 0);

        // R10 stall
        reg_write(3'd0, 16'h0001);
        reg_write(3'd1, 16'h0001);
        check("R10 stall set", stall, 4'b0010);
        reg_peek(3'd1, v); check("R10 stall read", v, 1);
        reg_write(3'd1, 16'h0020);
        check("R10 stall cleared", stall, 0);

        // R11 pulses
        @(negedge clk); reg_wr = 1; reg_addr = 3'd1; reg_wdata = 16'h0002;
        @(negedge clk); reg_wr = 0;
        check("R11 status pulse", {status_pulse, dstage_pulse, pulse_ep}, {2'b10, 4'd1});
        @(negedge clk);
        check("R11 pulse one cycle", status_pulse, 0);
        reg_write(3'd1, 16'h0004);
        check("R11 data stage pulse", {status_pulse, dstage_pulse}, 2'b01);

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule